// File: doc/BRIEF.md
# ADC Queue Scan Trigger Controller

This block decides when one conversion queue of an analog-to-digital converter begins a single scan. It also raises sticky interrupt requests when the queue sequencer reports a paused entry or the end of the queue. Software programs a 5-bit mode code together with an arm bit and two interrupt enables, all in one write strobe.

The mode code picks the trigger source:

| Code | Trigger source |
|---|---|
| 1 | Software |
| 2 | Rising edge of an external pin |
| 3 | Falling edge of an external pin |
| 4 to 12 | Interval timer clocked by conversion-clock ticks |
| 0, 13 to 31 | Queue disabled |

A trigger is accepted only while the arm bit is set. Each accepted trigger produces exactly one start pulse. The arm bit clears itself when the sequencer reports the last entry converted, and it always reads back as 0.

The control is a three-state machine:

- **IDLE**: not armed.
- **ARMED**: waiting for a trigger.
- **SCAN**: start issued, waiting for the end of the queue.

Transitions:

- **ARM**: IDLE to ARMED, on a write with arm=1 and an enabled mode.
- **FIRE**: ARMED to SCAN, on an accepted trigger with no write in that cycle. It issues the start pulse.
- **FINISH**: SCAN to IDLE, on entry-converted together with last-entry.
- **ABORT**: ARMED or SCAN to IDLE, on a write of a disabled mode code.

In every other case the state holds.

Top module: `adc_qscan_trig`

## Requirements
- R1: After reset the mode reads 0, both interrupt enables read 0, `start_pulse`, `pause_irq` and `done_irq` are 0, and `rd_arm` is 0.
- R2: Mode codes 0 and 13 to 31 are disabled. No start pulse ever occurs in them, an arm write in them is ignored, and writing such a code while armed or scanning returns the block to IDLE with no later start.
- R3: In mode 1, a write with arm=1 sampled at clock edge k gives `start_pulse` high for the single cycle after edge k+1.
- R4: In mode 2 while armed, if `ext_trig` is first sampled high at edge n after being low, `start_pulse` is high in the cycle after edge n+2. This latency comes from two synchronizer stages and the edge detector.
- R5: In mode 3 while armed, a high-to-low change of `ext_trig` first sampled at edge n gives `start_pulse` in the cycle after edge n+2.
- R6: In mode c (4 to 12) while armed, `start_pulse` rises after the 2^(c+3)-th `qclk_tick` counted from arming. Ticks outside ARMED are not counted, and any configuration write restarts the count.
- R7: Triggers while not armed cause no start. A write with arm=0 does not arm. `rd_arm` always reads 0.
- R8: After a start, further triggers cause no start until the scan completes (`seq_entry_done` and `seq_last_done` high together). After completion, the block needs a new arm write before the next start.
- R9: During SCAN with the pause enable set, `seq_entry_done` with `seq_pause_hit` sets `pause_irq` from the next cycle on. With the enable clear, it does not.
- R10: During SCAN with the completion enable set, the completion event sets `done_irq` from the next cycle on. With the enable clear, it does not.
- R11: `w1c_pause` / `w1c_done` high for a cycle clears the corresponding flag. A set event in the same cycle wins over the clear.
- R12: `start_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 5 | Mode code to write |
| cfg_arm | input | 1 | Arm bit to write (1 arms, 0 has no effect) |
| cfg_done_ie | input | 1 | Completion interrupt enable to write |
| cfg_pause_ie | input | 1 | Pause interrupt enable to write |
| w1c_pause | input | 1 | Write-one-to-clear strobe for the pause flag |
| w1c_done | input | 1 | Write-one-to-clear strobe for the completion flag |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| qclk_tick | input | 1 | One-cycle conversion clock tick |
| seq_entry_done | input | 1 | Sequencer: current entry converted |
| seq_pause_hit | input | 1 | Sequencer: that entry carried a pause mark |
| seq_last_done | input | 1 | Sequencer: that entry was the last of the queue |
| rd_mode | output | 5 | Readback of the stored mode code |
| rd_arm | output | 1 | Readback of the arm bit (always 0) |
| rd_done_ie | output | 1 | Readback of the completion enable |
| rd_pause_ie | output | 1 | Readback of the pause enable |
| start_pulse | output | 1 | One-cycle queue start request |
| pause_irq | output | 1 | Sticky pause interrupt request |
| done_irq | output | 1 | Sticky completion interrupt request |

## Verification
The trigger path is driven with four kinds of pattern:

- **Software arming** separates the one-cycle ARM-to-FIRE path from the pin paths.
- **Rising and falling pin changes** show that each mode reacts only to its own polarity, with the three-edge synchronizer latency.
- **Interval modes 4, 5 and 12 with a steady tick** measure the exact power-of-two count.
- **Triggers that arrive unarmed, mid-scan, after completion, or after an abort to a disabled code** show that the arm gating holds.

Sequencer strobes with the enables on and off, and clears coinciding with set events, separate the enable gating from the set-over-clear priority.

A behavioural model predicts every output on every cycle.

// File: rtl/qscan_pkg.sv
package qscan_pkg;

    localparam int MODE_W = 5;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t CODE_SW       = 5'd1;
    localparam mode_t CODE_RISE     = 5'd2;
    localparam mode_t CODE_FALL     = 5'd3;
    localparam mode_t CODE_TMR_BASE = 5'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SCAN  = 2'd2
    } scan_st_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_SW    = 3'd1,
        SRC_RISE  = 3'd2,
        SRC_FALL  = 3'd3,
        SRC_TIMER = 3'd4
    } trig_src_e;

    // Map a mode code onto its trigger source; out-of-range codes disable.
    function automatic trig_src_e src_of(mode_t code, mode_t last_tmr_code);
        trig_src_e s;
        if (code == CODE_SW)
            s = SRC_SW;
        else if (code == CODE_RISE)
            s = SRC_RISE;
        else if (code == CODE_FALL)
            s = SRC_FALL;
        else if (code >= CODE_TMR_BASE && code <= last_tmr_code)
            s = SRC_TIMER;
        else
            s = SRC_NONE;
        return s;
    endfunction

endpackage

// File: rtl/qscan_trig_sync.sv
module qscan_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;

    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)); // R4

endmodule

// File: rtl/qscan_ival_timer.sv
module qscan_ival_timer
    import qscan_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int BASE_EXP = 7
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  tick,
    input  mode_t code,
    output logic  hit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   last_val;
    int               exp_sel;

    always_comb begin
        exp_sel = int'(code) - int'(CODE_TMR_BASE) + BASE_EXP;
        if (exp_sel > CNT_W) exp_sel = CNT_W;
        if (exp_sel < 0)     exp_sel = 0;
        last_val = ({{CNT_W{1'b0}}, 1'b1} << exp_sel) - 1'b1;
    end

    assign hit = run && tick && ({1'b0, cnt_q} == last_val);

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, cnt_q} <= last_val)); // R6

endmodule

// File: rtl/qscan_irq_flags.sv
module qscan_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pause,
    input  logic set_done,
    input  logic clr_pause,
    input  logic clr_done,
    output logic pause_flag,
    output logic done_flag
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_flag <= 1'b0;
            done_flag  <= 1'b0;
        end else begin
            pause_flag <= set_pause | (pause_flag & ~clr_pause);
            done_flag  <= set_done  | (done_flag  & ~clr_done);
        end
    end

    AST_PAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_pause |=> pause_flag); // R9

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> done_flag); // R10

    AST_PAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pause && !set_pause) |=> !pause_flag); // R11

    AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !set_done) |=> !done_flag); // R11

endmodule

// File: rtl/adc_qscan_trig.sv
module adc_qscan_trig
    import qscan_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TMR_BASE_EXP  = 7,
    parameter int TMR_LAST_CODE = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_mode,
    input  logic        cfg_arm,
    input  logic        cfg_done_ie,
    input  logic        cfg_pause_ie,
    input  logic        w1c_pause,
    input  logic        w1c_done,
    input  logic        ext_trig,
    input  logic        qclk_tick,
    input  logic        seq_entry_done,
    input  logic        seq_pause_hit,
    input  logic        seq_last_done,
    output logic [4:0]  rd_mode,
    output logic        rd_arm,
    output logic        rd_done_ie,
    output logic        rd_pause_ie,
    output logic        start_pulse,
    output logic        pause_irq,
    output logic        done_irq
);

    localparam int    CNT_W     = TMR_BASE_EXP + TMR_LAST_CODE - int'(CODE_TMR_BASE);
    localparam mode_t LAST_CODE = mode_t'(TMR_LAST_CODE);

    mode_t     mode_q;
    logic      done_ie_q;
    logic      pause_ie_q;
    scan_st_e  st_q;
    scan_st_e  st_d;
    logic      start_d;
    logic      start_q;
    trig_src_e src_q;
    trig_src_e src_wr;
    logic      pin_rise;
    logic      pin_fall;
    logic      tmr_hit;
    logic      tmr_run;
    logic      trig_now;
    logic      scan_end;
    logic      set_pause;
    logic      set_done;

    assign src_q  = src_of(mode_q, LAST_CODE);
    assign src_wr = src_of(cfg_mode, LAST_CODE);

    qscan_trig_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_trig),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign tmr_run = (st_q == ST_ARMED) && (src_q == SRC_TIMER) && !cfg_we;

    qscan_ival_timer #(
        .CNT_W    (CNT_W),
        .BASE_EXP (TMR_BASE_EXP)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (qclk_tick),
        .code  (mode_q),
        .hit   (tmr_hit)
    );

    // Trigger condition for the selected source.
    always_comb begin
        unique case (src_q)
            SRC_SW:    trig_now = 1'b1;
            SRC_RISE:  trig_now = pin_rise;
            SRC_FALL:  trig_now = pin_fall;
            SRC_TIMER: trig_now = tmr_hit;
            default:   trig_now = 1'b0;
        endcase
    end

    assign scan_end = seq_entry_done && seq_last_done;

    // Next-state logic: ARM, FIRE, FINISH, ABORT.
    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cfg_we && cfg_arm && (src_wr != SRC_NONE))
                    st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cfg_we) begin
                    if (src_wr == SRC_NONE)
                        st_d = ST_IDLE;
                end else if (trig_now) begin
                    st_d    = ST_SCAN;
                    start_d = 1'b1;
                end
            end
            ST_SCAN: begin
                if (cfg_we && (src_wr == SRC_NONE))
                    st_d = ST_IDLE;
                else if (scan_end)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= 1'b0;
        else
            start_q <= start_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            done_ie_q  <= 1'b0;
            pause_ie_q <= 1'b0;
        end else if (cfg_we) begin
            mode_q     <= cfg_mode;
            done_ie_q  <= cfg_done_ie;
            pause_ie_q <= cfg_pause_ie;
        end
    end

    assign set_pause = (st_q == ST_SCAN) && seq_entry_done && seq_pause_hit && pause_ie_q;
    assign set_done  = (st_q == ST_SCAN) && scan_end && done_ie_q;

    qscan_irq_flags u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_pause  (set_pause),
        .set_done   (set_done),
        .clr_pause  (w1c_pause),
        .clr_done   (w1c_done),
        .pause_flag (pause_irq),
        .done_flag  (done_irq)
    );

    assign rd_mode     = mode_q;
    assign rd_arm      = 1'b0;
    assign rd_done_ie  = done_ie_q;
    assign rd_pause_ie = pause_ie_q;
    assign start_pulse = start_q;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q); // R12

    AST_START_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (st_q == ST_SCAN)); // R8

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_NONE) |-> (st_q == ST_IDLE)); // R2

    AST_SCAN_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SCAN) && scan_end) |=> (st_q == ST_IDLE)); // R8

    AST_NO_UNARMED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_ARMED) |=> !start_q); // R7

endmodule

// File: tb/adc_qscan_trig_tb.sv
module adc_qscan_trig_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_mode = '0;
    logic       cfg_arm = 1'b0;
    logic       cfg_done_ie = 1'b0;
    logic       cfg_pause_ie = 1'b0;
    logic       w1c_pause = 1'b0;
    logic       w1c_done = 1'b0;
    logic       ext_trig = 1'b0;
    logic       qclk_tick = 1'b1;
    logic       seq_entry_done = 1'b0;
    logic       seq_pause_hit = 1'b0;
    logic       seq_last_done = 1'b0;
    logic [4:0] rd_mode;
    logic       rd_arm;
    logic       rd_done_ie;
    logic       rd_pause_ie;
    logic       start_pulse;
    logic       pause_irq;
    logic       done_irq;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_qscan_trig dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_arm(cfg_arm), .cfg_done_ie(cfg_done_ie), .cfg_pause_ie(cfg_pause_ie),
        .w1c_pause(w1c_pause), .w1c_done(w1c_done), .ext_trig(ext_trig),
        .qclk_tick(qclk_tick), .seq_entry_done(seq_entry_done),
        .seq_pause_hit(seq_pause_hit), .seq_last_done(seq_last_done),
        .rd_mode(rd_mode), .rd_arm(rd_arm), .rd_done_ie(rd_done_ie),
        .rd_pause_ie(rd_pause_ie), .start_pulse(start_pulse),
        .pause_irq(pause_irq), .done_irq(done_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_state = 0;
    int m_mode = 0;
    int m_tcnt = 0;
    bit m_cie = 0, m_pie = 0, m_start = 0, m_pflag = 0, m_dflag = 0;
    bit p1 = 0, p2 = 0, p3 = 0;

    always @(posedge clk) begin : model
        bit r_e, f_e, fire, scan, ok_new;
        int per;
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_tcnt = 0; m_cie = 0; m_pie = 0;
            m_start = 0; m_pflag = 0; m_dflag = 0; p1 = 0; p2 = 0; p3 = 0;
        end else begin
            r_e = p2 && !p3;
            f_e = !p2 && p3;
            p3 = p2; p2 = p1; p1 = ext_trig;
            per = (m_mode >= 4 && m_mode <= 12) ? (1 << (m_mode + 3)) : 0;
            fire = 0;
            if (m_state == 1 && !cfg_we) begin
                if (m_mode == 1) fire = 1;
                else if (m_mode == 2) fire = r_e;
                else if (m_mode == 3) fire = f_e;
                else fire = qclk_tick && (m_tcnt == per - 1);
            end
            if (m_state == 1 && !cfg_we && per != 0) begin
                if (qclk_tick) m_tcnt = fire ? 0 : m_tcnt + 1;
            end else begin
                m_tcnt = 0;
            end
            scan = (m_state == 2);
            m_pflag = (scan && seq_entry_done && seq_pause_hit && m_pie) || (m_pflag && !w1c_pause);
            m_dflag = (scan && seq_entry_done && seq_last_done && m_cie) || (m_dflag && !w1c_done);
            m_start = fire;
            ok_new = (cfg_mode >= 1 && cfg_mode <= 12);
            if (m_state == 0) begin
                if (cfg_we && cfg_arm && ok_new) m_state = 1;
            end else if (m_state == 1) begin
                if (cfg_we && !ok_new) m_state = 0;
                else if (fire) m_state = 2;
            end else begin
                if (cfg_we && !ok_new) m_state = 0;
                else if (seq_entry_done && seq_last_done) m_state = 0;
            end
            if (cfg_we) begin
                m_mode = int'(cfg_mode); m_cie = cfg_done_ie; m_pie = cfg_pause_ie;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (start_pulse) n_start++;
            chk(start_pulse == m_start, "R3 R4 R5 R6 R12 start_pulse vs model", int'(start_pulse), int'(m_start));
            chk(pause_irq == m_pflag, "R9 R11 pause_irq vs model", int'(pause_irq), int'(m_pflag));
            chk(done_irq == m_dflag, "R10 R11 done_irq vs model", int'(done_irq), int'(m_dflag));
            chk(int'(rd_mode) == m_mode, "R1 rd_mode vs model", int'(rd_mode), m_mode);
            chk(rd_arm == 1'b0, "R7 rd_arm reads zero", int'(rd_arm), 0);
        end
    end

    task automatic cfg_write(input int mode, input bit arm, input bit cie, input bit pie);
        @(negedge clk);
        cfg_we = 1; cfg_mode = 5'(mode); cfg_arm = arm; cfg_done_ie = cie; cfg_pause_ie = pie;
        @(negedge clk);
        cfg_we = 0; cfg_arm = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic seq_evt(input bit pz, input bit last, input bit clr_d);
        @(negedge clk);
        seq_entry_done = 1; seq_pause_hit = pz; seq_last_done = last; w1c_done = clr_d;
        @(negedge clk);
        seq_entry_done = 0; seq_pause_hit = 0; seq_last_done = 0; w1c_done = 0;
    endtask

    task automatic clr(input bit cp, input bit cd);
        @(negedge clk);
        w1c_pause = cp; w1c_done = cd;
        @(negedge clk);
        w1c_pause = 0; w1c_done = 0;
    endtask

    task automatic wait_start(input int max, output int lat);
        lat = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (start_pulse) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic starts(output int n);
        #1 n = n_start;
    endtask

    task automatic pin_pulse();
        @(negedge clk) ext_trig = 1;
        idle(4);
        ext_trig = 0;
        idle(4);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        int s0, s1, lat;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk(rd_mode == 0, "R1 reset mode", int'(rd_mode), 0);
        chk(!rd_done_ie && !rd_pause_ie, "R1 reset enables", int'(rd_done_ie) + int'(rd_pause_ie), 0);
        chk(!start_pulse && !pause_irq && !done_irq, "R1 reset outputs", int'(start_pulse) + int'(pause_irq) + int'(done_irq), 0);

        // R2: disabled codes ignore arming and triggers
        starts(s0);
        cfg_write(0, 1, 1, 1);
        pin_pulse();
        cfg_write(13, 1, 1, 1);
        pin_pulse();
        idle(300);
        starts(s1);
        chk(s1 == s0, "R2 no start in disabled modes", s1 - s0, 0);

        // R7: unarmed and arm=0 writes give no start
        cfg_write(2, 0, 1, 1);
        pin_pulse();
        starts(s1);
        chk(s1 == s0, "R7 no start without arming", s1 - s0, 0);
        chk(rd_mode == 2 && rd_done_ie && rd_pause_ie, "R7 config stored", int'(rd_mode), 2);

        // R3: software mode
        cfg_write(1, 1, 1, 1);
        wait_start(10, lat);
        chk(lat == 1, "R3 software start latency", lat, 1);
        starts(s0);
        idle(6);
        starts(s1);
        chk(s1 == s0, "R8 single start while scanning", s1 - s0, 0);
        seq_evt(1, 0, 0);
        #1 chk(pause_irq == 1, "R9 pause flag set", int'(pause_irq), 1);
        chk(done_irq == 0, "R10 done not set by pause", int'(done_irq), 0);
        seq_evt(0, 1, 0);
        #1 chk(done_irq == 1, "R10 done flag set", int'(done_irq), 1);
        idle(6);
        starts(s1);
        chk(s1 == s0, "R8 no restart without re-arm", s1 - s0, 0);
        clr(1, 1);
        #1 chk(!pause_irq && !done_irq, "R11 flags cleared", int'(pause_irq) + int'(done_irq), 0);

        // R4: rising edge, pause enable off
        cfg_write(2, 1, 1, 0);
        idle(3);
        @(negedge clk) ext_trig = 1;
        wait_start(10, lat);
        chk(lat == 3, "R4 rising edge latency", lat, 3);
        starts(s0);
        pin_pulse();
        @(negedge clk) ext_trig = 1;
        idle(4);
        starts(s1);
        chk(s1 == s0, "R8 triggers ignored mid-scan", s1 - s0, 0);
        seq_evt(1, 0, 0);
        #1 chk(pause_irq == 0, "R9 pause enable off", int'(pause_irq), 0);
        seq_evt(0, 1, 1);
        #1 chk(done_irq == 1, "R11 set wins over clear", int'(done_irq), 1);
        clr(0, 1);
        #1 chk(done_irq == 0, "R11 done cleared", int'(done_irq), 0);

        // R5: falling edge (pin currently high)
        cfg_write(3, 1, 0, 0);
        idle(4);
        @(negedge clk) ext_trig = 0;
        wait_start(10, lat);
        chk(lat == 3, "R5 falling edge latency", lat, 3);
        seq_evt(0, 1, 0);
        #1 chk(done_irq == 0, "R10 done enable off", int'(done_irq), 0);

        // R6: interval timer
        cfg_write(4, 1, 0, 0);
        wait_start(1000, lat);
        chk(lat == 128, "R6 mode 4 interval", lat, 128);
        seq_evt(0, 1, 0);
        cfg_write(5, 1, 0, 0);
        wait_start(1000, lat);
        chk(lat == 256, "R6 mode 5 interval", lat, 256);
        seq_evt(0, 1, 0);
        cfg_write(12, 1, 0, 0);
        wait_start(40000, lat);
        chk(lat == 32768, "R6 mode 12 interval", lat, 32768);
        seq_evt(0, 1, 0);

        // R2: abort to disabled code while armed
        starts(s0);
        cfg_write(4, 1, 0, 0);
        idle(50);
        cfg_write(0, 0, 0, 0);
        idle(300);
        starts(s1);
        chk(s1 == s0, "R2 abort prevents start", s1 - s0, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule